// File: doc/BRIEF.md
# I2C Target Port for a 16-bit Register Bank

This block lets an external I2C master read and write a bank of 16-bit registers. SCL and SDA are brought into the system clock domain through two-flop synchronisers. Start, repeated start and stop conditions are decoded from the synchronised lines. The block drives SDA only as an open-drain pull-down enable.

A write transfer first loads a 10-bit register pointer from two address bytes. Every later pair of bytes is committed through a one-cycle register write strobe, and the pointer then moves on by one register. A read transfer starts from the pointer left by the last write. For each register it sends the high byte and then the low byte, and it keeps going until the master answers a byte with NACK.

The pointer never wraps. It saturates at the parameter `MAX_ADDR`. Once the register at the top address has been written, further write data is dropped. A read that reaches the top address returns that register over and over.

Top module: `i2c_word_port`

## Requirements
- R1: A start is SDA falling while SCL is high, and a stop is SDA rising while SCL is high. A repeated start begins a new transfer without a stop in between. After a stop, `sda_oe_o` is low.
- R2: The block answers only device addresses whose upper five bits are 0,1,0,1,1, with the two lowest address bits ignored. The eighth bit is R/W (0 = write, 1 = read). An address that does not match gets no ACK, and later bytes are ignored until the next start.
- R3: In a write transfer, the first two bytes after the device address form the pointer, high byte first. Only bits 9..0 are used (bits 1..0 of the first byte plus the whole second byte), and every byte gets a low ACK. If a transfer ends after a single address byte, the pointer is unchanged.
- R4: Each later byte pair is one register value, MSB first. It is written through a single-cycle `reg_we_o` pulse after the second byte. An unpaired final byte is discarded.
- R5: After each committed write, the pointer increases by one. The register at `MAX_ADDR` is written once, and all later write data in that transfer is dropped.
- R6: A read sends the high byte and then the low byte of the register at the pointer, then advances the pointer. It continues while the master ACKs and stops sending after a NACK.
- R7: When a read reaches `MAX_ADDR`, every further word returns that register.
- R8: SDA is driven only through `sda_oe_o` (1 = pull low). The enable changes only while the synchronised SCL is low, except for the release at a start or stop. It is low after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | I2C clock line |
| sda_i | input | 1 | I2C data line as seen on the bus |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| reg_we_o | output | 1 | Register write strobe, one cycle |
| reg_waddr_o | output | 10 | Register write address |
| reg_wdata_o | output | 16 | Register write data |
| reg_raddr_o | output | 10 | Register read address (current pointer) |
| reg_rdata_i | input | 16 | Register read data, combinational on reg_raddr_o |

## Verification
Two things fall in the same clock edge: committing the word at the top address and freezing the pointer there. Likewise, sending the last low byte at the top address coincides with deciding not to advance. Runs of writes and reads are started just below `MAX_ADDR` so that they cross it. The bench judges the result against a bench-side model of the bank and pointer, checking which registers changed, how many strobes were seen and which words came back. Random start addresses and run lengths then add more crossings of the boundary.

// File: rtl/i2c_word_pkg.sv
`timescale 1ns/1ps
package i2c_word_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_DEV, ST_RX, ST_ACK_OUT, ST_TX, ST_ACK_IN
  } state_e;

  // position within a write transfer
  typedef enum logic [1:0] {
    WP_AHI, WP_ALO, WP_DHI, WP_DLO
  } wphase_e;
endpackage

// File: rtl/i2c_word_sync.sv
`timescale 1ns/1ps
module i2c_word_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] ff_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) ff_q <= {STAGES{RST_VAL}};
    else         ff_q <= {ff_q[STAGES-2:0], d_i};

  assign q_o = ff_q[STAGES-1];
endmodule

// File: rtl/i2c_word_cond.sv
`timescale 1ns/1ps
module i2c_word_cond (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scl_s_i,
  input  logic sda_s_i,
  output logic scl_rise_o,
  output logic scl_fall_o,
  output logic start_o,
  output logic stop_o
);
  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end

  assign scl_rise_o = scl_s_i & ~scl_q;
  assign scl_fall_o = ~scl_s_i & scl_q;
  assign start_o    = scl_s_i & scl_q & sda_q & ~sda_s_i;
  assign stop_o     = scl_s_i & scl_q & ~sda_q & sda_s_i;
endmodule

// File: rtl/i2c_word_port.sv
`timescale 1ns/1ps
module i2c_word_port
  import i2c_word_pkg::*;
#(
  parameter int          MAX_ADDR   = 31,
  parameter logic [4:0]  DEV_PREFIX = 5'b01011,
  parameter int          SYNC_STG   = 2
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe_o,
  output logic        reg_we_o,
  output logic [9:0]  reg_waddr_o,
  output logic [15:0] reg_wdata_o,
  output logic [9:0]  reg_raddr_o,
  input  logic [15:0] reg_rdata_i
);
  localparam int PTR_W = 10;
  localparam int AHI_W = PTR_W - 8;
  localparam logic [PTR_W-1:0] MAX_P = PTR_W'(MAX_ADDR);

  logic scl_s, sda_s, scl_rise, scl_fall, cond_start, cond_stop;

  i2c_word_sync #(.STAGES(SYNC_STG)) u_sync_scl (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(scl_i), .q_o(scl_s));
  i2c_word_sync #(.STAGES(SYNC_STG)) u_sync_sda (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(sda_i), .q_o(sda_s));

  i2c_word_cond u_cond (
    .clk_i(clk_i), .rst_ni(rst_ni), .scl_s_i(scl_s), .sda_s_i(sda_s),
    .scl_rise_o(scl_rise), .scl_fall_o(scl_fall),
    .start_o(cond_start), .stop_o(cond_stop));

  state_e           state_q;
  wphase_e          wph_q;
  logic [2:0]       bit_cnt_q;
  logic [7:0]       sh_q;
  logic [AHI_W-1:0] ahi_q;
  logic [7:0]       dhi_q;
  logic [PTR_W-1:0] ptr_q;
  logic             past_end_q, rw_q, rd_lo_q, slot_q, nack_q, oe_q;
  logic             we_q;
  logic [PTR_W-1:0] waddr_q;
  logic [15:0]      wdata_q;

  logic [7:0] rx_byte, rd_byte;
  logic       at_max, in_range;

  assign rx_byte  = {sh_q[6:0], sda_s};
  assign rd_byte  = rd_lo_q ? reg_rdata_i[7:0] : reg_rdata_i[15:8];
  assign at_max   = (ptr_q == MAX_P);
  assign in_range = (ptr_q <= MAX_P);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      wph_q      <= WP_AHI;
      bit_cnt_q  <= '0;
      sh_q       <= '0;
      ahi_q      <= '0;
      dhi_q      <= '0;
      ptr_q      <= '0;
      past_end_q <= 1'b0;
      rw_q       <= 1'b0;
      rd_lo_q    <= 1'b0;
      slot_q     <= 1'b0;
      nack_q     <= 1'b0;
      oe_q       <= 1'b0;
      we_q       <= 1'b0;
      waddr_q    <= '0;
      wdata_q    <= '0;
    end else begin
      we_q <= 1'b0;
      if (cond_start) begin
        state_q   <= ST_DEV;
        wph_q     <= WP_AHI;
        bit_cnt_q <= '0;
        rd_lo_q   <= 1'b0;
        slot_q    <= 1'b0;
        oe_q      <= 1'b0;
      end else if (cond_stop) begin
        state_q <= ST_IDLE;
        oe_q    <= 1'b0;
      end else begin
        unique case (state_q)
          ST_DEV, ST_RX: if (scl_rise) begin
            sh_q      <= rx_byte;
            bit_cnt_q <= bit_cnt_q + 3'd1;
            if (bit_cnt_q == 3'd7) begin
              slot_q <= 1'b0;
              if (state_q == ST_DEV) begin
                if (rx_byte[7:3] == DEV_PREFIX) begin
                  rw_q    <= rx_byte[0];
                  state_q <= ST_ACK_OUT;
                end else begin
                  state_q <= ST_IDLE;
                end
              end else begin
                state_q <= ST_ACK_OUT;
                unique case (wph_q)
                  WP_AHI: begin
                    ahi_q <= rx_byte[AHI_W-1:0];
                    wph_q <= WP_ALO;
                  end
                  WP_ALO: begin
                    ptr_q      <= {ahi_q, rx_byte};
                    past_end_q <= 1'b0;
                    wph_q      <= WP_DHI;
                  end
                  WP_DHI: begin
                    dhi_q <= rx_byte;
                    wph_q <= WP_DLO;
                  end
                  default: begin
                    wph_q <= WP_DHI;
                    if (in_range && !past_end_q) begin
                      we_q    <= 1'b1;
                      waddr_q <= ptr_q;
                      wdata_q <= {dhi_q, rx_byte};
                      if (at_max) past_end_q <= 1'b1;
                      else        ptr_q <= ptr_q + PTR_W'(1);
                    end
                  end
                endcase
              end
            end
          end
          ST_ACK_OUT: if (scl_fall) begin
            if (!slot_q) begin
              oe_q   <= 1'b1;
              slot_q <= 1'b1;
            end else begin
              slot_q    <= 1'b0;
              bit_cnt_q <= '0;
              if (rw_q) begin
                state_q <= ST_TX;
                sh_q    <= rd_byte;
                oe_q    <= ~rd_byte[7];
              end else begin
                state_q <= ST_RX;
                oe_q    <= 1'b0;
              end
            end
          end
          ST_TX: begin
            if (scl_rise) begin
              bit_cnt_q <= bit_cnt_q + 3'd1;
              if (bit_cnt_q == 3'd7) begin
                state_q <= ST_ACK_IN;
                slot_q  <= 1'b0;
                rd_lo_q <= ~rd_lo_q;
                if (rd_lo_q && (ptr_q < MAX_P)) ptr_q <= ptr_q + PTR_W'(1);
              end
            end else if (scl_fall) begin
              sh_q <= {sh_q[6:0], sh_q[7]};
              oe_q <= ~sh_q[6];
            end
          end
          ST_ACK_IN: begin
            if (scl_rise) begin
              nack_q <= sda_s;
              slot_q <= 1'b1;
            end else if (scl_fall) begin
              if (!slot_q) begin
                oe_q <= 1'b0;
              end else begin
                slot_q <= 1'b0;
                if (!nack_q) begin
                  state_q   <= ST_TX;
                  bit_cnt_q <= '0;
                  sh_q      <= rd_byte;
                  oe_q      <= ~rd_byte[7];
                end else begin
                  state_q <= ST_IDLE;
                end
              end
            end
          end
          default: ;
        endcase
      end
    end
  end

  assign sda_oe_o    = oe_q;
  assign reg_we_o    = we_q;
  assign reg_waddr_o = waddr_q;
  assign reg_wdata_o = wdata_q;
  assign reg_raddr_o = ptr_q;
endmodule

// File: rtl/i2c_word_port_chk.sv
`timescale 1ns/1ps
module i2c_word_port_chk #(
  parameter int MAX_ADDR = 31
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       scl_s,
  input logic       scl_rise,
  input logic       cond_start,
  input logic       cond_stop,
  input logic       sda_oe_o,
  input logic       reg_we_o,
  input logic [9:0] reg_waddr_o
);
  assert_oe_scl_low_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(sda_oe_o) |-> (!$past(scl_s) || $past(cond_start) || $past(cond_stop)));

  assert_stop_release_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cond_stop |=> !sda_oe_o);

  assert_we_range_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> (reg_waddr_o <= 10'(MAX_ADDR)));

  assert_we_pulse_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |=> !reg_we_o);

  assert_we_on_edge_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_we_o |-> $past(scl_rise));
endmodule

bind i2c_word_port i2c_word_port_chk #(.MAX_ADDR(MAX_ADDR)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .scl_s(scl_s), .scl_rise(scl_rise),
  .cond_start(cond_start), .cond_stop(cond_stop), .sda_oe_o(sda_oe_o),
  .reg_we_o(reg_we_o), .reg_waddr_o(reg_waddr_o));

// File: tb/i2c_word_port_bench.sv
`timescale 1ns/1ps
module i2c_word_port_bench;
  localparam int MAX_ADDR = 31;
  localparam int Q = 6;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst_n = 1'b0;
  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, we;
  logic [9:0] waddr, raddr;
  logic [15:0] wdata, rdata;
  wire sda_line = sda_m & ~sda_oe;

  logic [15:0] mem [0:MAX_ADDR];
  logic [15:0] exp_mem [0:MAX_ADDR];
  logic [15:0] wbuf [0:7];
  int exp_ptr, we_cnt, n_tests, n_fail;
  bit done;

  assign rdata = (raddr <= 10'(MAX_ADDR)) ? mem[raddr] : 16'hDEAD;

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i <= MAX_ADDR; i++) mem[i] <= 16'(i * 257) ^ 16'h5A5A;
      we_cnt <= 0;
    end else if (we) begin
      if (waddr <= 10'(MAX_ADDR)) mem[waddr] <= wdata;
      we_cnt <= we_cnt + 1;
    end
  end

  i2c_word_port #(.MAX_ADDR(MAX_ADDR)) u_i2c_word_port (
    .clk_i(clk), .rst_ni(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe_o(sda_oe), .reg_we_o(we), .reg_waddr_o(waddr), .reg_wdata_o(wdata),
    .reg_raddr_o(raddr), .reg_rdata_i(rdata));

  task automatic tick(int n); repeat (n) @(negedge clk); endtask

  task automatic check(bit ok, string tag, logic [31:0] act, logic [31:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, expv);
    end
  endtask

  function automatic logic [6:0] dev_addr();
    return {5'b01011, 2'($urandom_range(0, 3))};
  endfunction

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output bit ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
    end
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q);
    ack = !sda_line;
    tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic recv_byte(input bit nack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(Q); scl_m = 1'b1; tick(Q); b[i] = sda_line; tick(Q); scl_m = 1'b0;
    end
    tick(Q); sda_m = nack; tick(Q); scl_m = 1'b1; tick(2 * Q); scl_m = 1'b0; tick(Q);
    sda_m = 1'b1;
  endtask

  // write transfer: pointer bytes then n words from wbuf; returns AND of all ACKs
  task automatic do_write(input int addr, input logic [5:0] junk, input int n,
                          input bit stop_after, output bit all_ack);
    bit a;
    bus_start();
    send_byte({dev_addr(), 1'b0}, a); all_ack = a;
    send_byte({junk, 2'(addr >> 8)}, a); all_ack &= a;
    send_byte(8'(addr), a); all_ack &= a;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i][15:8], a); all_ack &= a;
      send_byte(wbuf[i][7:0], a); all_ack &= a;
    end
    if (stop_after) bus_stop();
  endtask

  function automatic void model_write(int addr, int n);
    int p = addr;
    bit pe = 1'b0;
    for (int i = 0; i < n; i++)
      if (p <= MAX_ADDR && !pe) begin
        exp_mem[p] = wbuf[i];
        if (p == MAX_ADDR) pe = 1'b1; else p++;
      end
    exp_ptr = p;
  endfunction

  task automatic do_read(input int n, input string tag);
    bit a;
    logic [7:0] hi, lo;
    logic [15:0] ev;
    bus_start();
    send_byte({dev_addr(), 1'b1}, a);
    check(a, {tag, " read address ACK"}, 32'(a), 1);
    for (int i = 0; i < n; i++) begin
      ev = (exp_ptr <= MAX_ADDR) ? exp_mem[exp_ptr] : 16'hDEAD;
      recv_byte(1'b0, hi);
      recv_byte(i == n - 1, lo);
      check({hi, lo} == ev, {tag, " read word"}, {hi, lo}, ev);
      if (exp_ptr < MAX_ADDR) exp_ptr++;
    end
    bus_stop();
  endtask

  task automatic check_mem(input string tag);
    int bad = -1;
    for (int i = MAX_ADDR; i >= 0; i--) if (mem[i] !== exp_mem[i]) bad = i;
    if (bad < 0) check(1'b1, tag, 0, 0);
    else check(1'b0, tag, {bad[15:0], mem[bad]}, {bad[15:0], exp_mem[bad]});
  endtask

  initial begin
    bit ack;
    int base, n, addr;
    void'($urandom(32'd20240611));
    n_tests = 0; n_fail = 0; exp_ptr = 0;
    for (int i = 0; i <= MAX_ADDR; i++) exp_mem[i] = 16'(i * 257) ^ 16'h5A5A;
    tick(5); rst_n = 1'b1; tick(5);

    // R8: idle state after reset
    check(sda_oe == 1'b0, "R8 oe after reset", 32'(sda_oe), 0);
    check(we == 1'b0, "R4 no strobe after reset", 32'(we), 0);
    check(raddr == 10'd0, "R3 pointer after reset", 32'(raddr), 0);

    // R2: foreign device address, no ACK, following byte ignored
    base = we_cnt;
    bus_start();
    send_byte({7'b0111100, 1'b0}, ack);
    check(!ack, "R2 foreign address NACK", 32'(ack), 0);
    send_byte(8'h00, ack);
    check(!ack, "R2 byte after foreign address ignored", 32'(ack), 0);
    bus_stop();
    check(we_cnt == base, "R2 no write strobes", 32'(we_cnt - base), 0);

    // R3/R4: pointer with junk upper bits, three words
    for (int i = 0; i < 3; i++) wbuf[i] = 16'($urandom);
    do_write(5, 6'h3F, 3, 1'b1, ack);
    model_write(5, 3);
    check(ack, "R3 all write bytes ACKed", 32'(ack), 1);
    check_mem("R4 words committed MSB first");

    // R1/R6: pointer load then repeated start into a read
    do_write(5, 6'h00, 0, 1'b0, ack);
    exp_ptr = 5;
    do_read(3, "R1 R6 repeated start");

    // R3: single pointer byte then stop leaves pointer as the read left it
    bus_start();
    send_byte({dev_addr(), 1'b0}, ack);
    send_byte(8'h00, ack);
    bus_stop();
    do_read(1, "R3 one address byte");

    // R4: unpaired trailing byte dropped
    base = we_cnt;
    wbuf[0] = 16'hC3A5;
    do_write(10, 6'h00, 1, 1'b0, ack);
    send_byte(8'h77, ack);
    bus_stop();
    model_write(10, 1);
    check(we_cnt - base == 1, "R4 one strobe for odd byte count", 32'(we_cnt - base), 1);
    check_mem("R4 odd byte leaves next register");

    // R5: run crossing the top address
    base = we_cnt;
    for (int i = 0; i < 3; i++) wbuf[i] = 16'($urandom);
    do_write(MAX_ADDR - 1, 6'h15, 3, 1'b1, ack);
    model_write(MAX_ADDR - 1, 3);
    check(we_cnt - base == 2, "R5 writes past top dropped", 32'(we_cnt - base), 2);
    check_mem("R5 top address contents");

    // R7: read run crossing the top address
    do_write(MAX_ADDR - 1, 6'h00, 0, 1'b0, ack);
    exp_ptr = MAX_ADDR - 1;
    do_read(4, "R7 read at top");

    // R5/R6: random runs
    for (int k = 0; k < 8; k++) begin
      addr = $urandom_range(0, MAX_ADDR);
      n = $urandom_range(1, 4);
      for (int i = 0; i < n; i++) wbuf[i] = 16'($urandom);
      do_write(addr, 6'($urandom), n, 1'b1, ack);
      model_write(addr, n);
      check(ack, "R3 random write ACKs", 32'(ack), 1);
      check_mem("R5 random write");
      do_write(addr, 6'h00, 0, 1'b0, ack);
      exp_ptr = addr;
      do_read(n, "R6 random read");
    end

    check(sda_oe == 1'b0, "R1 bus released at end", 32'(sda_oe), 0);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule